// File: doc/BRIEF.md
# ADC Conversion Pacer and Trigger Controller

This block issues the start-of-conversion strobe for an analog-to-digital converter. Every part of it runs on a single reference clock, nominally 10 MHz. A chain of selectable decade prescalers feeds two cascaded 16-bit down-counters, and these form an internal pacer. The period of the pacer is the prescaled period multiplied by both divisors. A source select field routes one of three sources to a one-cycle conversion strobe: a software write, the pacer, or an edge on an external clock pin.

Two external inputs control the pacer. An external trigger can hold the pacer off until an edge of a chosen polarity arrives, and that edge then stays latched until software clears it. An external gate can restrict pacer conversions to a window in which the gate is active. All three external pins pass through two-flop synchronizers before they are used. Software configures the block through a small write-only register port.

Top module: `adc_pacer_ctrl`

## Requirements
- R1: After reset, `conv_strobe` is low, the source is off (code 11), both divisors are 1, the prescaler is set to divide by 1, and the trigger is disabled.
- R2: Address 0 writes divisor A (first counter) and address 1 writes divisor B (second counter), each taking `wr_data[15:0]`. Address 2 writes the control fields: [1:0] source, [2] trigger polarity, [3] trigger enable, [5:4] prescale. Prescale 0 divides by 1, 1 by 10, and 2 or 3 by 100. Address 3 is the software convert strobe.
- R3: With the pacer selected, the strobes come exactly 10^prescale × A × B reference cycles apart. The first strobe after a control write with the clear bit set comes that many cycles after the write edge.
- R4: A divisor value of 0 counts as 65536.
- R5: While the synchronized gate input is low, the pacer produces no strobes.
- R6: The source codes are 00 for software, 01 for pacer, 10 for external clock and 11 for off. With code 11, no stimulus produces a strobe.
- R7: A write to address 3 gives exactly one strobe cycle on the next cycle, but only while the software source is selected. In every other mode it is ignored.
- R8: With the external clock selected, each rising edge of `ext_clk_in` gives exactly one strobe cycle, 3 cycles after the input changes. A falling edge gives none.
- R9: With trigger enable set, the pacer and the prescaler are held in reload until an edge of the selected polarity arrives on `ext_trig_in` (0 = rising, 1 = falling). The trigger then stays latched and pacing continues, with the first strobe 3 + 10^prescale × A × B cycles after the input edge.
- R10: Bit 6 of a control write clears the latched trigger and restarts both counters and the prescaler from their programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (timebase) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| ext_clk_in | input | 1 | External conversion clock, asynchronous |
| ext_trig_in | input | 1 | External trigger, asynchronous |
| ext_gate_in | input | 1 | External pacer gate, asynchronous, active high |
| conv_strobe | output | 1 | One-cycle start-of-conversion strobe |

## Verification
The bench measures the exact first-strobe latency after a clear and after a trigger edge. It measures the steady period for every prescale setting, including the clamped code 3. A counter that reloads one cycle late, or a cascade that adds a register, shifts these counts. A divisor of 0 must yield a 65536-cycle period; a design that treats it as zero or one would strobe almost at once.

Several sources are driven while unselected or blocked, to confirm that each is ignored:
- software writes outside software mode;
- external clock edges outside external mode;
- a trigger edge of the wrong polarity;
- pacing while the gate is low.

A design that leaks any of these would show extra strobes in those windows. The bench also checks that the trigger stays latched after the trigger input returns, and that a clear drops the latch again.

// File: rtl/adc_pacer_pkg.sv
package adc_pacer_pkg;

  localparam int unsigned DIV_W = 16;
  localparam int unsigned CNT_W = DIV_W + 1;

  typedef enum logic [1:0] {
    SRC_SW    = 2'b00,
    SRC_PACER = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_OFF   = 2'b11
  } conv_src_e;

  // Divisor as programmed -> actual count length; zero means 2**DIV_W.
  function automatic logic [CNT_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    if (d == '0) return {1'b1, {DIV_W{1'b0}}};
    return {1'b0, d};
  endfunction

endpackage

// File: rtl/pacer_sync.sv
module pacer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/pacer_prescaler.sv
module pacer_prescaler #(
  parameter int unsigned N_DECADES = 2,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned RADIX = 10;
  localparam int unsigned DIG_W = $clog2(RADIX);

  logic [N_DECADES:0] stage_tick;
  assign stage_tick[0] = 1'b1;

  for (genvar g = 0; g < N_DECADES; g++) begin : g_decade
    logic [DIG_W-1:0] digit;
    assign stage_tick[g+1] = stage_tick[g] && (digit == DIG_W'(RADIX - 1));
    always_ff @(posedge clk) begin
      if (!rst_n || clr)          digit <= '0;
      else if (stage_tick[g+1])   digit <= '0;
      else if (stage_tick[g])     digit <= digit + 1'b1;
    end
  end

  logic [SEL_W-1:0] sel_c;
  assign sel_c = (sel > SEL_W'(N_DECADES)) ? SEL_W'(N_DECADES) : sel;
  assign tick  = stage_tick[sel_c] && !clr;
endmodule

// File: rtl/pacer_downcounter.sv
module pacer_downcounter
  import adc_pacer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tc
);
  logic [CNT_W-1:0] cnt;

  assign tc = en && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= CNT_W'(1);
    else if (load)   cnt <= eff_div(div);
    else if (tc)     cnt <= eff_div(div);
    else if (en)     cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/adc_pacer_ctrl.sv
module adc_pacer_ctrl
  import adc_pacer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned N_DECADES = 2,
  parameter int unsigned SYNC_FF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_clk_in,
  input  logic              ext_trig_in,
  input  logic              ext_gate_in,
  output logic              conv_strobe
);
  localparam int unsigned PS_W = 2;
  localparam logic [ADDR_W-1:0] A_DIVA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIVB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SWCV = ADDR_W'(3);

  // Configuration
  logic [DIV_W-1:0] div_a, div_b;
  conv_src_e        src_q;
  logic             trig_pol_q, trig_en_q;
  logic [PS_W-1:0]  ps_sel_q;

  // Named internal events (observed by the checker)
  logic wr_ctrl, clr_wr, sw_wr;
  logic gate_s, gate_unused_r, gate_unused_f;
  logic ext_rise, ext_lvl_unused, ext_fall_unused;
  logic trig_rise, trig_fall, trig_lvl_unused;
  logic trig_hit, trig_latched, hold, load;
  logic ps_tick, tc1, pacer_tick;
  logic conv_d;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign clr_wr  = wr_ctrl && wr_data[6];
  assign sw_wr   = wr_en && (wr_addr == A_SWCV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_a      <= DIV_W'(1);
      div_b      <= DIV_W'(1);
      src_q      <= SRC_OFF;
      trig_pol_q <= 1'b0;
      trig_en_q  <= 1'b0;
      ps_sel_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_DIVA) div_a <= wr_data[DIV_W-1:0];
      if (wr_addr == A_DIVB) div_b <= wr_data[DIV_W-1:0];
      if (wr_ctrl) begin
        src_q      <= conv_src_e'(wr_data[1:0]);
        trig_pol_q <= wr_data[2];
        trig_en_q  <= wr_data[3];
        ps_sel_q   <= wr_data[5:4];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wr_data[DATA_W-1:7], ext_lvl_unused, ext_fall_unused,
                          trig_lvl_unused, gate_unused_r, gate_unused_f};

  // Synchronizers
  pacer_sync #(.STAGES(SYNC_FF)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in),
    .level(ext_lvl_unused), .rise(ext_rise), .fall(ext_fall_unused));
  pacer_sync #(.STAGES(SYNC_FF)) u_sync_trig (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig_in),
    .level(trig_lvl_unused), .rise(trig_rise), .fall(trig_fall));
  pacer_sync #(.STAGES(SYNC_FF)) u_sync_gate (
    .clk(clk), .rst_n(rst_n), .async_in(ext_gate_in),
    .level(gate_s), .rise(gate_unused_r), .fall(gate_unused_f));

  // Trigger latch
  assign trig_hit = trig_en_q && (trig_pol_q ? trig_fall : trig_rise);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_wr) trig_latched <= 1'b0;
    else if (trig_hit)    trig_latched <= 1'b1;
  end

  assign hold = trig_en_q && !trig_latched;
  assign load = clr_wr || hold;

  // Divider chain
  pacer_prescaler #(.N_DECADES(N_DECADES), .SEL_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(load), .sel(ps_sel_q), .tick(ps_tick));

  pacer_downcounter u_cnt_a (
    .clk(clk), .rst_n(rst_n), .load(load), .en(ps_tick), .div(div_a), .tc(tc1));

  pacer_downcounter u_cnt_b (
    .clk(clk), .rst_n(rst_n), .load(load), .en(tc1), .div(div_b), .tc(pacer_tick));

  // Source multiplexer and output register
  always_comb begin
    unique case (src_q)
      SRC_SW:    conv_d = sw_wr;
      SRC_PACER: conv_d = pacer_tick && gate_s;
      SRC_EXT:   conv_d = ext_rise;
      default:   conv_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) conv_strobe <= 1'b0;
    else        conv_strobe <= conv_d;
  end
endmodule

// File: rtl/adc_pacer_checker.sv
module adc_pacer_checker
  import adc_pacer_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_q,
  input logic       sw_wr,
  input logic       clr_wr,
  input logic       gate_s,
  input logic       trig_en_q,
  input logic       trig_latched,
  input logic       tc1,
  input logic       pacer_tick,
  input logic       conv_strobe
);
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_OFF) |=> !conv_strobe);

  p_gate_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_PACER && !gate_s) |=> !conv_strobe);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en_q && !trig_latched) |-> !pacer_tick);

  p_latch_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_latched && !clr_wr) |=> trig_latched);

  p_cascade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pacer_tick |-> tc1);

  p_sw_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_SW && !sw_wr) |=> !conv_strobe);

  p_sw_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_SW && sw_wr) |=> conv_strobe);
endmodule

bind adc_pacer_ctrl adc_pacer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_q(src_q), .sw_wr(sw_wr), .clr_wr(clr_wr),
  .gate_s(gate_s), .trig_en_q(trig_en_q), .trig_latched(trig_latched),
  .tc1(tc1), .pacer_tick(pacer_tick), .conv_strobe(conv_strobe));

// File: tb/test_adc_pacer_ctrl.sv
`timescale 1ns/1ps
module test_adc_pacer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_clk_in = 1'b0;
  logic        ext_trig_in = 1'b0;
  logic        ext_gate_in = 1'b1;
  logic        conv_strobe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_pacer_ctrl i_adc_pacer_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk_in(ext_clk_in), .ext_trig_in(ext_trig_in), .ext_gate_in(ext_gate_in),
    .conv_strobe(conv_strobe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2 control layout: [1:0] src, [2] pol, [3] trig enable, [5:4] prescale, [6] clear
  task automatic ctrl(input logic [1:0] src, input bit pol, input bit ten,
                      input logic [1:0] ps, input bit clr);
    wr(2'd2, {9'd0, clr, ps, ten, pol, src});
  endtask

  task automatic wait_strobe(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (conv_strobe) begin n = i; break; end
    end
  endtask

  task automatic count_strobes(input int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (conv_strobe) c++;
    end
  endtask

  task automatic t_reset;
    int c;
    chk(conv_strobe == 1'b0, "R1 strobe low", conv_strobe, 0);
    ext_clk_in = 1'b1;
    count_strobes(20, c);
    chk(c == 0, "R1 source off after reset", c, 0);
    ext_clk_in = 1'b0;
    wr(2'd3, 16'd0);
    count_strobes(5, c);
    chk(c == 0, "R1 R6 sw write while off", c, 0);
  endtask

  task automatic t_pacer;
    int n;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd3);
    ctrl(2'b01, 0, 0, 2'd0, 1);
    wait_strobe(100, n);
    chk(n == 6, "R3 first strobe after clear", n, 6);
    @(negedge clk);
    chk(conv_strobe == 1'b0, "R3 strobe one cycle wide", conv_strobe, 0);
    wait_strobe(100, n);
    chk(n == 5, "R3 steady period", n + 1, 6);
  endtask

  task automatic t_prescale;
    int n;
    ctrl(2'b01, 0, 0, 2'd1, 1);
    wait_strobe(200, n);
    chk(n == 60, "R3 prescale /10 first", n, 60);
    wait_strobe(200, n);
    chk(n == 60, "R3 prescale /10 period", n, 60);
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd1);
    ctrl(2'b01, 0, 0, 2'd2, 1);
    wait_strobe(300, n);
    chk(n == 100, "R3 prescale /100 first", n, 100);
    ctrl(2'b01, 0, 0, 2'd3, 1);
    wait_strobe(300, n);
    chk(n == 100, "R2 prescale code 3 clamps to /100", n, 100);
  endtask

  task automatic t_div_zero;
    int n;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd1);
    ctrl(2'b01, 0, 0, 2'd0, 1);
    wait_strobe(70000, n);
    chk(n == 65536, "R4 divisor zero is 65536", n, 65536);
  endtask

  task automatic t_gate;
    int c;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd1);
    ext_gate_in = 1'b0;
    repeat (4) @(negedge clk);
    ctrl(2'b01, 0, 0, 2'd0, 1);
    count_strobes(40, c);
    chk(c == 0, "R5 gate low blocks pacer", c, 0);
    ext_gate_in = 1'b1;
    count_strobes(24, c);
    chk(c >= 10, "R5 gate high allows pacer", c, 10);
  endtask

  task automatic t_sw;
    int c;
    ctrl(2'b00, 0, 0, 2'd0, 1);
    wr(2'd3, 16'd0);
    chk(conv_strobe == 1'b1, "R7 sw strobe fires", conv_strobe, 1);
    @(negedge clk);
    chk(conv_strobe == 1'b0, "R7 sw strobe one cycle", conv_strobe, 0);
    ctrl(2'b10, 0, 0, 2'd0, 1);
    wr(2'd3, 16'd0);
    count_strobes(10, c);
    chk(c == 0, "R7 sw write ignored in ext mode", c, 0);
  endtask

  task automatic t_off;
    int c;
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd1);
    ctrl(2'b11, 0, 0, 2'd0, 1);
    ext_clk_in = 1'b1;
    count_strobes(15, c);
    ext_clk_in = 1'b0;
    wr(2'd3, 16'd0);
    count_strobes(15, c);
    chk(c == 0, "R6 off mode silent", c, 0);
  endtask

  task automatic t_ext;
    int n;
    int c;
    ctrl(2'b10, 0, 0, 2'd0, 1);
    repeat (3) @(negedge clk);
    ext_clk_in = 1'b1;
    wait_strobe(20, n);
    chk(n == 3, "R8 ext edge latency", n, 3);
    @(negedge clk);
    chk(conv_strobe == 1'b0, "R8 ext strobe one cycle", conv_strobe, 0);
    ext_clk_in = 1'b0;
    count_strobes(10, c);
    chk(c == 0, "R8 falling edge ignored", c, 0);
    c = 0;
    for (int k = 0; k < 5; k++) begin
      int cc;
      ext_clk_in = 1'b1;
      count_strobes(4, cc);
      c += cc;
      ext_clk_in = 1'b0;
      count_strobes(4, cc);
      c += cc;
    end
    chk(c == 5, "R8 one strobe per rising edge", c, 5);
  endtask

  task automatic t_trig;
    int n;
    int c;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd3);
    ctrl(2'b01, 0, 1, 2'd0, 1);
    count_strobes(50, c);
    chk(c == 0, "R9 pacer held before trigger", c, 0);
    ext_trig_in = 1'b1;
    wait_strobe(100, n);
    chk(n == 9, "R9 first strobe after rising trigger", n, 9);
    ext_trig_in = 1'b0;
    count_strobes(60, c);
    chk(c == 10, "R9 trigger stays latched", c, 10);
    ctrl(2'b01, 1, 1, 2'd0, 1);
    ext_trig_in = 1'b1;
    count_strobes(40, c);
    chk(c == 0, "R9 rising edge ignored with falling polarity", c, 0);
    ext_trig_in = 1'b0;
    wait_strobe(100, n);
    chk(n == 9, "R9 first strobe after falling trigger", n, 9);
  endtask

  task automatic t_clear;
    int n;
    int c;
    ctrl(2'b01, 1, 1, 2'd0, 1);
    count_strobes(40, c);
    chk(c == 0, "R10 clear drops trigger latch", c, 0);
    ctrl(2'b01, 0, 0, 2'd0, 1);
    wait_strobe(20, n);
    repeat (3) @(negedge clk);
    ctrl(2'b01, 0, 0, 2'd0, 1);
    wait_strobe(20, n);
    chk(n == 6, "R10 clear restarts counters", n, 6);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pacer();
    t_prescale();
    t_div_zero();
    t_gate();
    t_sw();
    t_off();
    t_ext();
    t_trig();
    t_clear();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end
endmodule